// File: doc/BRIEF.md
# Two-wire serial slave with an eight-byte control register bank

This block lets a host on a two-wire serial bus (I2C or SMBus style) read and write eight byte-wide control registers inside the chip. The clock and data wires come in as plain inputs. A two-flop synchronizer samples them on the fast system clock, and every bus event is detected from those synchronized samples. The slave never drives the clock wire. It acts on the data wire only through an open-drain pull-down enable: when the enable is high the pad pulls the wire low, and when it is low the wire is released.

The device address is seven bits. The two top bits come from strap inputs and the five lower bits are fixed at `01011`. Register access follows the byte protocol of the bus. A write sends the address with the write flag, then a register-select byte, then one data byte. A read sends the address with the write flag and the register-select byte, then a repeated START, then the address with the read flag, and the slave answers with one byte. Only the three low bits of the register-select byte are used, and they become an internal pointer that a repeated START does not clear. Every register is visible to the rest of the chip on a flat output bus.

Top module: `i2c_regbank_slave`

## Requirements
- R1: While reset is held and just after it is released, `sda_oe_o` is 0 and all eight registers read 0 on `regs_o`.
- R2: A STOP (data rising while the clock is high) ends any transfer and releases the data wire. A START (data falling while the clock is high) always begins address reception.
- R3: The first byte after a START is acknowledged when its seven MSB-first address bits equal {`strap_i`[1:0], 0,1,0,1,1}. The slave acknowledges by driving `sda_oe_o` high for the ninth clock.
- R4: `sda_oe_o` changes only after the clock has fallen, or because of a START or STOP. It stays constant while the clock is high.
- R5: An acknowledge holds the data wire low for the whole high phase of the ninth clock. The wire is released after that clock falls.
- R6: In a write (address bit 0 = 0), the register-select byte's bits [2:0] pick the register and its bits [7:3] are ignored. That register takes the value of the following data byte.
- R7: After a repeated START with the read flag (address bit 0 = 1), the slave sends the register at the stored pointer, most significant bit first. A data bit of 0 is sent as `sda_oe_o` = 1.
- R8: After the eighth bit of the read byte, the slave releases the data wire for the master's acknowledge clock. It stays released until the next START, whether the master sent ACK (0) or NACK (1).
- R9: A START or a STOP that arrives before a data byte is complete leaves every register unchanged.
- R10: An address byte that does not match is not acknowledged. The slave then keeps the data wire released until the next START.
- R11: In a write, any byte that follows the data byte gets no acknowledge and writes no register.
- R12: Register n appears on `regs_o`[8n+7:8n] at all times.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, much faster than the bus clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock wire level |
| sda_i | input | 1 | Bus data wire level |
| strap_i | input | 2 | Strap inputs giving the top two address bits |
| sda_oe_o | output | 1 | 1 = pull the data wire low |
| regs_o | output | 64 | Contents of the eight registers, register 0 in the low byte |

## Verification
A bus wire changes on one system edge and is held in the second synchronizer flop two edges later. The edge detector then marks the change, so the FSM updates `sda_oe_o` three clock edges after the clock wire falls, and a register write lands one edge after that. The bench drives each bus half-period for 16 system clocks. Its reference model predicts the data-wire drive and the register image for each high phase of the bus clock. It compares them with the outputs on every system clock once the clock wire has been high for five cycles, so every expected result is already due when it is compared. Acknowledge bits and read bits are also sampled in the middle of the high phase and checked against their expected values.

// File: rtl/i2cs_pkg.sv
package i2cs_pkg;

    localparam int BYTE_W = 8;
    localparam int PTR_W  = 3;
    localparam int NREG   = 1 << PTR_W;
    localparam int CNT_W  = 4;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_ADDR,
        ST_AACK,
        ST_REG,
        ST_PACK,
        ST_WDATA,
        ST_DACK,
        ST_RDATA,
        ST_MACK,
        ST_WAIT
    } i2cs_state_e;

    typedef struct packed {
        i2cs_state_e        state;
        logic [CNT_W-1:0]   cnt;
        logic [BYTE_W-1:0]  sh;
        logic [BYTE_W-1:0]  tx;
        logic [PTR_W-1:0]   ptr;
        logic               rw;
        logic               oe;
        logic               wr_en;
        logic [BYTE_W-1:0]  wr_data;
    } i2cs_fsm_t;

endpackage

// File: rtl/i2cs_sync.sv
module i2cs_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic sda_o,
    output logic rise_o,
    output logic fall_o,
    output logic start_o,
    output logic stop_o
);

    logic [STAGES-1:0] scl_pipe_d, scl_pipe_q;
    logic [STAGES-1:0] sda_pipe_d, sda_pipe_q;
    logic scl_last_d, scl_last_q;
    logic sda_last_d, sda_last_q;
    logic scl_now;

    for (genvar g = 0; g < STAGES; g++) begin : g_stage
        if (g == 0) begin : g_first
            assign scl_pipe_d[g] = scl_i;
            assign sda_pipe_d[g] = sda_i;
        end else begin : g_next
            assign scl_pipe_d[g] = scl_pipe_q[g-1];
            assign sda_pipe_d[g] = sda_pipe_q[g-1];
        end
    end

    assign scl_now = scl_pipe_q[STAGES-1];
    assign sda_o   = sda_pipe_q[STAGES-1];

    always_comb begin
        scl_last_d = scl_now;
        sda_last_d = sda_o;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_pipe_q <= '1;
            sda_pipe_q <= '1;
            scl_last_q <= 1'b1;
            sda_last_q <= 1'b1;
        end else begin
            scl_pipe_q <= scl_pipe_d;
            sda_pipe_q <= sda_pipe_d;
            scl_last_q <= scl_last_d;
            sda_last_q <= sda_last_d;
        end
    end

    assign rise_o  = scl_now & ~scl_last_q;
    assign fall_o  = ~scl_now & scl_last_q;
    assign start_o = scl_now & scl_last_q & sda_last_q & ~sda_o;
    assign stop_o  = scl_now & scl_last_q & ~sda_last_q & sda_o;

endmodule

// File: rtl/i2cs_fsm.sv
module i2cs_fsm
    import i2cs_pkg::*;
#(
    parameter int ADDR_W  = 7,
    parameter int STRAP_W = 2,
    parameter logic [ADDR_W-STRAP_W-1:0] FIXED_BITS = 5'b01011
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [STRAP_W-1:0] strap_i,
    input  logic               sda_i,
    input  logic               rise_i,
    input  logic               fall_i,
    input  logic               start_i,
    input  logic               stop_i,
    input  logic [BYTE_W-1:0]  rd_data_i,
    output logic               oe_o,
    output logic [PTR_W-1:0]   ptr_o,
    output logic               wr_en_o,
    output logic [BYTE_W-1:0]  wr_data_o
);

    localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_W);

    i2cs_fsm_t q, d;
    logic [ADDR_W-1:0] dev_addr;

    assign dev_addr = {strap_i, FIXED_BITS};

    always_comb begin
        d       = q;
        d.wr_en = 1'b0;
        if (stop_i) begin
            d.state = ST_IDLE;
            d.oe    = 1'b0;
            d.cnt   = '0;
        end else if (start_i) begin
            d.state = ST_ADDR;
            d.oe    = 1'b0;
            d.cnt   = '0;
        end else begin
            case (q.state)
                ST_ADDR, ST_REG, ST_WDATA: begin
                    if (rise_i) begin
                        d.sh  = {q.sh[BYTE_W-2:0], sda_i};
                        d.cnt = q.cnt + 1'b1;
                    end else if (fall_i && q.cnt == LAST_BIT) begin
                        d.cnt = '0;
                        if (q.state == ST_ADDR) begin
                            if (q.sh[BYTE_W-1 -: ADDR_W] == dev_addr) begin
                                d.rw    = q.sh[0];
                                d.oe    = 1'b1;
                                d.state = ST_AACK;
                            end else begin
                                d.state = ST_WAIT;
                            end
                        end else if (q.state == ST_REG) begin
                            d.ptr   = q.sh[PTR_W-1:0];
                            d.oe    = 1'b1;
                            d.state = ST_PACK;
                        end else begin
                            d.wr_en   = 1'b1;
                            d.wr_data = q.sh;
                            d.oe      = 1'b1;
                            d.state   = ST_DACK;
                        end
                    end
                end
                ST_AACK, ST_PACK, ST_DACK: begin
                    if (fall_i) begin
                        d.oe  = 1'b0;
                        d.cnt = '0;
                        if (q.state == ST_AACK) begin
                            if (q.rw) begin
                                d.state = ST_RDATA;
                                d.tx    = rd_data_i;
                                d.oe    = ~rd_data_i[BYTE_W-1];
                            end else begin
                                d.state = ST_REG;
                            end
                        end else if (q.state == ST_PACK) begin
                            d.state = ST_WDATA;
                        end else begin
                            d.state = ST_WAIT;
                        end
                    end
                end
                ST_RDATA: begin
                    if (rise_i) begin
                        d.cnt = q.cnt + 1'b1;
                    end else if (fall_i) begin
                        if (q.cnt == LAST_BIT) begin
                            d.oe    = 1'b0;
                            d.cnt   = '0;
                            d.state = ST_MACK;
                        end else begin
                            d.tx = {q.tx[BYTE_W-2:0], 1'b0};
                            d.oe = ~q.tx[BYTE_W-2];
                        end
                    end
                end
                ST_MACK: begin
                    if (rise_i) begin
                        d.state = ST_WAIT;
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '{state: ST_IDLE, default: '0};
        end else begin
            q <= d;
        end
    end

    assign oe_o      = q.oe;
    assign ptr_o     = q.ptr;
    assign wr_en_o   = q.wr_en;
    assign wr_data_o = q.wr_data;

    // R2: a STOP always leaves the data wire released
    a_r2_stop_releases: assert property (@(posedge clk) disable iff (!rst_n)
        stop_i |=> !q.oe);

    // R4: the drive moves only in reaction to a clock fall or a bus condition
    a_r4_drive_on_low_clock: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(q.oe) |-> ($past(fall_i) || $past(start_i) || $past(stop_i)));

    // R3: an address acknowledge only follows a byte equal to the device address
    a_r3_ack_only_on_match: assert property (@(posedge clk) disable iff (!rst_n)
        (q.state == ST_AACK) |-> (q.sh[BYTE_W-1 -: ADDR_W] == dev_addr));

    // R8, R10: quiet states never pull the data wire
    a_r8_quiet_states: assert property (@(posedge clk) disable iff (!rst_n)
        (q.state == ST_MACK || q.state == ST_WAIT || q.state == ST_IDLE) |-> !q.oe);

endmodule

// File: rtl/i2cs_regfile.sv
module i2cs_regfile #(
    parameter int DATA_W = 8,
    parameter int PTR_W  = 3
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     wr_en_i,
    input  logic [PTR_W-1:0]         wr_addr_i,
    input  logic [DATA_W-1:0]        wr_data_i,
    input  logic [PTR_W-1:0]         rd_addr_i,
    output logic [DATA_W-1:0]        rd_data_o,
    output logic [(DATA_W<<PTR_W)-1:0] regs_o
);

    localparam int NREG = 1 << PTR_W;

    logic [DATA_W-1:0] mem_d [NREG];
    logic [DATA_W-1:0] mem_q [NREG];

    for (genvar g = 0; g < NREG; g++) begin : g_reg
        always_comb begin
            mem_d[g] = (wr_en_i && wr_addr_i == PTR_W'(g)) ? wr_data_i : mem_q[g];
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                mem_q[g] <= '0;
            end else begin
                mem_q[g] <= mem_d[g];
            end
        end

        assign regs_o[g*DATA_W +: DATA_W] = mem_q[g];
    end

    assign rd_data_o = mem_q[rd_addr_i];

    // R6: a write request lands in the addressed register one edge later
    a_r6_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en_i |=> (mem_q[$past(wr_addr_i)] == $past(wr_data_i)));

    // R9, R11: without a write request the register image holds
    a_r9_no_stray_write: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en_i |=> $stable(regs_o));

endmodule

// File: rtl/i2c_regbank_slave.sv
module i2c_regbank_slave
    import i2cs_pkg::*;
#(
    parameter int STRAP_W     = 2,
    parameter int SYNC_STAGES = 2,
    parameter logic [4:0] FIXED_BITS = 5'b01011
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               scl_i,
    input  logic               sda_i,
    input  logic [STRAP_W-1:0] strap_i,
    output logic               sda_oe_o,
    output logic [NREG*BYTE_W-1:0] regs_o
);

    logic              sda_s, rise, fall, start_c, stop_c;
    logic [BYTE_W-1:0] rd_data, wr_data;
    logic [PTR_W-1:0]  ptr;
    logic              wr_en;

    i2cs_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .scl_i   (scl_i),
        .sda_i   (sda_i),
        .sda_o   (sda_s),
        .rise_o  (rise),
        .fall_o  (fall),
        .start_o (start_c),
        .stop_o  (stop_c)
    );

    i2cs_fsm #(
        .ADDR_W     (7),
        .STRAP_W    (STRAP_W),
        .FIXED_BITS (FIXED_BITS)
    ) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .strap_i   (strap_i),
        .sda_i     (sda_s),
        .rise_i    (rise),
        .fall_i    (fall),
        .start_i   (start_c),
        .stop_i    (stop_c),
        .rd_data_i (rd_data),
        .oe_o      (sda_oe_o),
        .ptr_o     (ptr),
        .wr_en_o   (wr_en),
        .wr_data_o (wr_data)
    );

    i2cs_regfile #(.DATA_W(BYTE_W), .PTR_W(PTR_W)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en_i   (wr_en),
        .wr_addr_i (ptr),
        .wr_data_i (wr_data),
        .rd_addr_i (ptr),
        .rd_data_o (rd_data),
        .regs_o    (regs_o)
    );

endmodule

// File: tb/sim_i2c_regbank_slave.sv
`timescale 1ns/1ps
module sim_i2c_regbank_slave;

    localparam int HALF = 16;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        scl_m = 1'b1;
    logic        sda_m = 1'b1;
    logic [1:0]  strap = 2'b10;
    logic        sda_oe;
    logic [63:0] regs;
    logic        sda_bus;

    logic [7:0]  model_mem [8];
    logic        exp_oe = 1'b0;
    string       tag = "R1";
    int          hi_cnt = 0;
    int          checks = 0;
    int          errors = 0;
    bit          done = 1'b0;

    always #5 clk = ~clk;

    assign sda_bus = sda_m & ~sda_oe;

    i2c_regbank_slave u0 (
        .clk      (clk),
        .rst_n    (rst_n),
        .scl_i    (scl_m),
        .sda_i    (sda_bus),
        .strap_i  (strap),
        .sda_oe_o (sda_oe),
        .regs_o   (regs)
    );

    function automatic logic [63:0] model_flat();
        logic [63:0] v;
        for (int i = 0; i < 8; i++) v[i*8 +: 8] = model_mem[i];
        return v;
    endfunction

    task automatic chk(input bit ok, input string r, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h at %0t", r, act, exp, $time);
        end
    endtask

    // per-clock comparison against the reference model while the bus clock is settled high
    always @(posedge clk) hi_cnt <= scl_m ? hi_cnt + 1 : 0;

    always @(negedge clk) begin
        if (rst_n && scl_m && hi_cnt >= 5 && !done) begin
            chk(sda_oe === exp_oe, tag, 64'(sda_oe), 64'(exp_oe));
            chk(regs === model_flat(), "R12", regs, model_flat());
        end
    end

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
        #1;
    endtask

    task automatic clk_bit(input bit drv, input bit exp, input string t, output bit seen);
        sda_m = drv;
        tick(HALF);
        exp_oe = exp;
        tag = t;
        scl_m = 1'b1;
        tick(HALF/2);
        seen = sda_bus;
        tick(HALF - HALF/2);
        scl_m = 1'b0;
        tick(HALF);
    endtask

    task automatic bus_start();
        exp_oe = 1'b0;
        tag = "R2";
        sda_m = 1'b1;
        tick(HALF);
        scl_m = 1'b1;
        tick(HALF);
        sda_m = 1'b0;
        tick(HALF);
        scl_m = 1'b0;
        tick(HALF);
    endtask

    task automatic bus_stop();
        exp_oe = 1'b0;
        tag = "R2";
        sda_m = 1'b0;
        tick(HALF);
        scl_m = 1'b1;
        tick(HALF);
        sda_m = 1'b1;
        tick(HALF);
        chk(sda_oe == 1'b0, "R2", 64'(sda_oe), 64'd0);
    endtask

    task automatic send_byte(input logic [7:0] b, input bit exp_ack, input string t,
                             input int upd_idx);
        bit s;
        for (int i = 7; i >= 0; i--) clk_bit(b[i], 1'b0, "R4", s);
        if (upd_idx >= 0) model_mem[upd_idx] = b;
        clk_bit(1'b1, exp_ack, {t, "/R5"}, s);
        chk((s == 1'b0) == exp_ack, t, 64'(!s), 64'(exp_ack));
    endtask

    task automatic recv_byte(input logic [7:0] exp, input bit m_ack, output logic [7:0] got);
        bit s;
        for (int i = 7; i >= 0; i--) begin
            clk_bit(1'b1, ~exp[i], "R7", s);
            got[i] = s;
        end
        clk_bit(m_ack ? 1'b0 : 1'b1, 1'b0, "R8", s);
    endtask

    function automatic logic [7:0] addr_byte(input logic [1:0] st, input bit rd);
        return {st, 5'b01011, rd};
    endfunction

    task automatic write_reg(input logic [7:0] sel, input logic [7:0] data);
        bus_start();
        send_byte(addr_byte(strap, 1'b0), 1'b1, "R3", -1);
        send_byte(sel, 1'b1, "R6", -1);
        send_byte(data, 1'b1, "R6", int'(sel[2:0]));
        bus_stop();
    endtask

    task automatic read_reg(input logic [7:0] sel, input bit m_ack, input bit extra);
        logic [7:0] got;
        bit s;
        bus_start();
        send_byte(addr_byte(strap, 1'b0), 1'b1, "R3", -1);
        send_byte(sel, 1'b1, "R7", -1);
        bus_start();
        send_byte(addr_byte(strap, 1'b1), 1'b1, "R7", -1);
        recv_byte(model_mem[sel[2:0]], m_ack, got);
        chk(got == model_mem[sel[2:0]], "R7", 64'(got), 64'(model_mem[sel[2:0]]));
        if (extra) begin
            // R8: after a master ACK the slave stays silent for a whole further byte
            for (int i = 0; i < 9; i++) clk_bit(1'b1, 1'b0, "R8", s);
            chk(s == 1'b1, "R8", 64'(s), 64'd1);
        end
        bus_stop();
    endtask

    initial begin
        bit s;
        for (int i = 0; i < 8; i++) model_mem[i] = 8'h00;
        tick(6);
        // R1: reset state
        chk(sda_oe == 1'b0, "R1", 64'(sda_oe), 64'd0);
        chk(regs == 64'd0, "R1", regs, 64'd0);
        rst_n = 1'b1;
        tick(4);
        chk(sda_oe == 1'b0, "R1", 64'(sda_oe), 64'd0);
        chk(regs == 64'd0, "R1", regs, 64'd0);

        // R3, R6: plain write with strap 10
        write_reg(8'h03, 8'hA5);
        chk(regs[31:24] == 8'hA5, "R6", 64'(regs[31:24]), 64'hA5);

        // R7: read back through repeated START, master NACK
        read_reg(8'h03, 1'b0, 1'b0);

        // R6: upper select bits ignored on write and on read
        write_reg(8'hFD, 8'h3C);
        chk(regs[47:40] == 8'h3C, "R6", 64'(regs[47:40]), 64'h3C);
        read_reg(8'h05, 1'b0, 1'b0);
        read_reg(8'hE5, 1'b0, 1'b0);

        // R10: address with the wrong strap bits
        bus_start();
        send_byte(addr_byte(2'b01, 1'b0), 1'b0, "R10", -1);
        send_byte(8'h02, 1'b0, "R10", -1);
        send_byte(8'hEE, 1'b0, "R10", -1);
        bus_stop();
        chk(regs[23:16] == 8'h00, "R10", 64'(regs[23:16]), 64'h00);

        // R3: a new strap value moves the address
        strap = 2'b01;
        tick(4);
        write_reg(8'h00, 8'h81);
        chk(regs[7:0] == 8'h81, "R3", 64'(regs[7:0]), 64'h81);

        // R8: master ACK after the read byte
        read_reg(8'h00, 1'b1, 1'b1);

        // R9: STOP in the middle of the data byte
        bus_start();
        send_byte(addr_byte(strap, 1'b0), 1'b1, "R3", -1);
        send_byte(8'h02, 1'b1, "R9", -1);
        for (int i = 0; i < 4; i++) clk_bit(1'b0, 1'b0, "R9", s);
        bus_stop();
        chk(regs[23:16] == 8'h00, "R9", 64'(regs[23:16]), 64'h00);

        // R9, R2: START in the middle of the data byte, then a fresh write
        bus_start();
        send_byte(addr_byte(strap, 1'b0), 1'b1, "R3", -1);
        send_byte(8'h02, 1'b1, "R9", -1);
        for (int i = 0; i < 3; i++) clk_bit(1'b0, 1'b0, "R9", s);
        bus_start();
        send_byte(addr_byte(strap, 1'b0), 1'b1, "R2", -1);
        send_byte(8'h04, 1'b1, "R6", -1);
        send_byte(8'h77, 1'b1, "R6", 4);
        bus_stop();
        chk(regs[23:16] == 8'h00, "R9", 64'(regs[23:16]), 64'h00);
        chk(regs[39:32] == 8'h77, "R9", 64'(regs[39:32]), 64'h77);

        // R11: a byte after the data byte is refused
        bus_start();
        send_byte(addr_byte(strap, 1'b0), 1'b1, "R3", -1);
        send_byte(8'h06, 1'b1, "R6", -1);
        send_byte(8'h11, 1'b1, "R6", 6);
        send_byte(8'h22, 1'b0, "R11", -1);
        bus_stop();
        chk(regs[55:48] == 8'h11, "R11", 64'(regs[55:48]), 64'h11);
        chk(regs[63:56] == 8'h00, "R11", 64'(regs[63:56]), 64'h00);

        // R12: the full image matches the model
        chk(regs == model_flat(), "R12", regs, model_flat());

        tick(10);
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog R2 actual=running expected=finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule